// File: doc/BRIEF.md
# Delta-Sigma Result Serial Formatter

This block sits between the digital back end of a delta-sigma converter and its serial host port. Each time the back end strobes a new signed result, the block clamps it to the converter's full-scale span, encodes it as a sign bit plus an offset data field, and keeps it as the pending result. The host reads the result by pulling chip select low and clocking 24 bits out of the serial data line, most significant bit first. The top bit of the word tells the host whether the result is new.

The result arrives in LSBs of the full-scale scale, so full scale is 2^DATA_BITS LSB (65536 with the defaults). Over-range and under-range inputs saturate to their own codes. A zero result normally reads as positive. In double-rate mode its sign bit alternates from one conversion to the next. The serial pins are synchronised into the system clock domain. A result that arrives while the host is reading is held back and only becomes pending once chip select returns high.

Top module: `dsr_serial_formatter`

## Requirements
- R1: After reset the block reports no pending result (`ready_o` = 0) and, while deselected, `sdo_o` is 1.
- R2: The 24-bit word is {status, 0, code[17:0], 0000}. Bit 23 (status) is 0 when a fresh result is pending at the start of the transfer and 1 otherwise. Bit 22 is always 0. Bits 3..0 are always 0. If no fresh result is pending, the previous code is repeated.
- R3: A result v with 0 < v < 65536 gives code = 2^17 + v. This means bit 21 (sign) is 1 and bits 20..4 carry v.
- R4: A result v with -65536 <= v < 0 gives code = 2^17 + v. Bit 21 is 0, so -1 gives 0x1FFFF, -32768 gives 0x18000 and -65536 gives 0x10000.
- R5: A result v >= 65536 saturates to code 0x30000.
- R6: A result v < -65536 saturates to code 0x0FFFF.
- R7: With `dbl_rate_i` = 0, a zero result gives code 0x20000 (sign 1, data 0).
- R8: A phase flag is set to 1 by reset and by every result accepted in 1x mode. Every result accepted in double-rate mode inverts it. A zero result accepted in double-rate mode takes the flag's prior value as its sign: code 0x20000 when the flag is 1, 0x00000 when it is 0.
- R9: `sck_i` is low when chip select falls. `sdo_o` presents bit 23 first and moves to the next lower bit after each falling edge of `sck_i`. The host samples on rising edges.
- R10: An accepted result sets `ready_o` while deselected. `ready_o` clears only on the 24th rising `sck_i` edge of a transfer. A transfer aborted earlier leaves it set.
- R11: A result accepted while chip select is low does not change the word being shifted or `ready_o`. It becomes the pending result when chip select returns high.
- R12: While deselected, `sdo_o` equals the inverse of `ready_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_i | input | RES_W | Signed conversion result in LSBs |
| res_valid_i | input | 1 | One-cycle strobe: `res_i` is a new result |
| dbl_rate_i | input | 1 | Double-rate mode flag |
| sck_i | input | 1 | Serial clock from the host |
| cs_n_i | input | 1 | Active-low chip select from the host |
| sdo_o | output | 1 | Serial data out |
| ready_o | output | 1 | An unread result is pending |

## Verification
Some properties are checked on every cycle. These are the range of the encoder output and the 1x zero code. They also cover the dummy and tail positions of the shifted word, the idle level of `sdo_o` against `ready_o`, and the fact that `ready_o` can neither clear outside a transfer nor rise while selected. The bench alone shows the exact codes for values at each scale boundary and across a sweep of the whole input range. It also shows the sign alternation of zero over several double-rate conversions, the 24-bit clear point, aborted reads, and a result deferred behind a transfer in progress.

// File: rtl/dsr_fmt_pkg.sv
package dsr_fmt_pkg;
   // serial clock events seen inside the system clock domain
   typedef struct packed {
      logic rise;
      logic fall;
   } sck_evt_t;

   // status bit plus dummy bit above the sign/data field
   localparam int unsigned HDR_BITS = 2;
endpackage

// File: rtl/dsr_in_sync.sv
module dsr_in_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ff <= {STAGES{RST_VAL}};
            end else begin
               ff[0] <= d;
               for (int i = 1; i < STAGES; i++) begin
                  ff[i] <= ff[i-1];
               end
            end
         end
         assign q = ff[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/dsr_code_map.sv
module dsr_code_map #(
   parameter int RES_W     = 20,
   parameter int DATA_BITS = 16,
   localparam int FW       = DATA_BITS + 2
) (
   input  logic signed [RES_W-1:0] res_i,
   input  logic                    zero_sign_i,
   output logic        [FW-1:0]    code_o
);
   localparam logic signed [RES_W-1:0] FS_POS = RES_W'(2 ** DATA_BITS);
   localparam logic signed [RES_W-1:0] FS_NEG = -FS_POS;
   localparam logic [FW-1:0] MID  = {2'b10, {DATA_BITS{1'b0}}};
   localparam logic [FW-1:0] OVER = {2'b11, {DATA_BITS{1'b0}}};
   localparam logic [FW-1:0] UNDR = {2'b00, {DATA_BITS{1'b1}}};

   always_comb begin
      if (res_i >= FS_POS) begin
         code_o = OVER;
      end else if (res_i < FS_NEG) begin
         code_o = UNDR;
      end else if (res_i == '0) begin
         code_o = zero_sign_i ? MID : '0;
      end else begin
         code_o = res_i[FW-1:0] + MID;
      end
   end
endmodule

// File: rtl/dsr_shift_out.sv
module dsr_shift_out #(
   parameter int WORD_W = 24,
   parameter int POS_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic              shift_i,
   output logic              sdo_o,
   output logic [POS_W-1:0]  pos_o
);
   logic [WORD_W-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr    <= {1'b1, {(WORD_W-1){1'b0}}};
         pos_o <= '0;
      end else if (load_i) begin
         sr    <= word_i;
         pos_o <= '0;
      end else if (shift_i) begin
         sr <= {sr[WORD_W-2:0], 1'b0};
         if (pos_o != POS_W'(WORD_W)) pos_o <= pos_o + 1'b1;
      end
   end

   assign sdo_o = sr[WORD_W-1];
endmodule

// File: rtl/dsr_serial_formatter.sv
module dsr_serial_formatter
   import dsr_fmt_pkg::*;
#(
   parameter int RES_W       = 20,
   parameter int DATA_BITS   = 16,
   parameter int TAIL_BITS   = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [RES_W-1:0] res_i,
   input  logic                    res_valid_i,
   input  logic                    dbl_rate_i,
   input  logic                    sck_i,
   input  logic                    cs_n_i,
   output logic                    sdo_o,
   output logic                    ready_o
);
   localparam int FW     = DATA_BITS + 2;
   localparam int WORD_W = HDR_BITS + FW + TAIL_BITS;
   localparam int POS_W  = $clog2(WORD_W + 1);

   generate
      if (RES_W < FW || RES_W > 31) begin : g_bad_res_w
         $error("RES_W must cover DATA_BITS+2 and stay below 32");
      end
      if (DATA_BITS < 2) begin : g_bad_data
         $error("DATA_BITS must be at least 2");
      end
      if (TAIL_BITS < 0 || SYNC_STAGES < 0) begin : g_bad_misc
         $error("TAIL_BITS and SYNC_STAGES must not be negative");
      end
   endgenerate

   // host pins into the clk domain
   logic     cs_n_s, sck_s, sck_d, cs_sel;
   sck_evt_t evt;

   dsr_in_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
      .clk(clk), .rst_n(rst_n), .d(cs_n_i), .q(cs_n_s)
   );
   dsr_in_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
      .clk(clk), .rst_n(rst_n), .d(sck_i), .q(sck_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;
   end

   assign cs_sel   = ~cs_n_s;
   assign evt.rise = sck_s & ~sck_d & cs_sel;
   assign evt.fall = ~sck_s & sck_d & cs_sel;

   // zero-sign phase and encoding
   logic          zphase;
   logic          zero_sign;
   logic [FW-1:0] new_code;

   assign zero_sign = dbl_rate_i ? zphase : 1'b1;

   dsr_code_map #(.RES_W(RES_W), .DATA_BITS(DATA_BITS)) u_map (
      .res_i(res_i), .zero_sign_i(zero_sign), .code_o(new_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           zphase <= 1'b1;
      else if (res_valid_i) zphase <= dbl_rate_i ? ~zphase : 1'b1;
   end

   // pending result and deferred result
   logic [FW-1:0]    pend_code, hold_code;
   logic             pend, hold_v;
   logic [POS_W-1:0] bit_pos;
   logic             last_rise;

   assign last_rise = evt.rise && (bit_pos == POS_W'(WORD_W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_code <= '0;
         hold_code <= '0;
         pend      <= 1'b0;
         hold_v    <= 1'b0;
      end else if (!cs_sel) begin
         if (res_valid_i) begin
            pend_code <= new_code;
            pend      <= 1'b1;
            hold_v    <= 1'b0;
         end else if (hold_v) begin
            pend_code <= hold_code;
            pend      <= 1'b1;
            hold_v    <= 1'b0;
         end
      end else begin
         if (res_valid_i) begin
            hold_code <= new_code;
            hold_v    <= 1'b1;
         end
         if (last_rise) pend <= 1'b0;
      end
   end

   // word assembly and shifter
   logic [WORD_W-1:0] word;

   generate
      if (TAIL_BITS > 0) begin : g_tail
         assign word = {~pend, 1'b0, pend_code, {TAIL_BITS{1'b0}}};
      end else begin : g_no_tail
         assign word = {~pend, 1'b0, pend_code};
      end
   endgenerate

   dsr_shift_out #(.WORD_W(WORD_W), .POS_W(POS_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load_i(~cs_sel), .word_i(word),
      .shift_i(evt.fall), .sdo_o(sdo_o), .pos_o(bit_pos)
   );

   assign ready_o = pend;
endmodule

// File: rtl/dsr_formatter_chk.sv
module dsr_formatter_chk #(
   parameter int RES_W     = 20,
   parameter int DATA_BITS = 16,
   parameter int TAIL_BITS = 4,
   localparam int FW       = DATA_BITS + 2,
   localparam int WORD_W   = 2 + FW + TAIL_BITS,
   localparam int POS_W    = $clog2(WORD_W + 1)
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    cs_sel,
   input logic [POS_W-1:0]        bit_pos,
   input logic                    sdo_o,
   input logic                    ready_o,
   input logic                    res_valid_i,
   input logic signed [RES_W-1:0] res_i,
   input logic                    dbl_rate_i,
   input logic [FW-1:0]           code
);
   localparam logic [FW-1:0] MID  = {2'b10, {DATA_BITS{1'b0}}};
   localparam logic [FW-1:0] OVER = {2'b11, {DATA_BITS{1'b0}}};
   localparam logic [FW-1:0] UNDR = {2'b00, {DATA_BITS{1'b1}}};

   AST_IDLE_SDO_EOC: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!cs_sel) |-> (sdo_o == !$past(ready_o)));                           // R12

   AST_DUMMY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_sel && bit_pos == POS_W'(1)) |-> !sdo_o);                             // R2

   AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_sel && bit_pos >= POS_W'(WORD_W - TAIL_BITS)) |-> !sdo_o);            // R2

   AST_NO_RISE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_sel && !ready_o) |=> !ready_o);                                       // R11

   AST_CLEAR_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready_o) |-> $past(cs_sel));                                        // R10

   AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_i |-> (code == '0 || (code >= UNDR && code <= OVER)));          // R5

   AST_ZERO_1X: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_i && !dbl_rate_i && res_i == '0) |-> (code == MID));           // R7
endmodule

bind dsr_serial_formatter dsr_formatter_chk #(
   .RES_W(RES_W), .DATA_BITS(DATA_BITS), .TAIL_BITS(TAIL_BITS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_sel(cs_sel), .bit_pos(bit_pos),
   .sdo_o(sdo_o), .ready_o(ready_o), .res_valid_i(res_valid_i),
   .res_i(res_i), .dbl_rate_i(dbl_rate_i), .code(new_code)
);

// File: tb/tb_dsr_serial_formatter.sv
module tb_dsr_serial_formatter;
   localparam int FS = 65536;
   localparam int H  = 6;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic signed [19:0] res = '0;
   logic               valid = 1'b0;
   logic               dbl = 1'b0;
   logic               sck = 1'b0;
   logic               cs_n = 1'b1;
   logic               sdo, ready;

   int          checks = 0;
   int          failures = 0;
   logic [23:0] rx;
   logic [17:0] last_code = '0;
   bit          mz = 1'b1;

   always #10 clk = ~clk;

   dsr_serial_formatter dut (
      .clk(clk), .rst_n(rst_n), .res_i(res), .res_valid_i(valid),
      .dbl_rate_i(dbl), .sck_i(sck), .cs_n_i(cs_n), .sdo_o(sdo), .ready_o(ready)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [17:0] exp_code(input int v, input bit zs);
      if (v >= FS)       return 18'h30000;
      else if (v < -FS)  return 18'h0FFFF;
      else if (v == 0)   return zs ? 18'h20000 : 18'h00000;
      else               return 18'(v + 131072);
   endfunction

   function automatic string tag_of(input int v, input bit d);
      if (v >= FS)      return "R5";
      else if (v < -FS) return "R6";
      else if (v == 0)  return d ? "R8" : "R7";
      else if (v > 0)   return "R3";
      else              return "R4";
   endfunction

   // returns expected code and updates the bench's own phase model
   task automatic send(input int v, input bit d, output logic [17:0] ec);
      bit used;
      used = d ? mz : 1'b1;
      mz   = d ? ~mz : 1'b1;
      ec   = exp_code(v, used);
      @(negedge clk);
      res   <= v[19:0];
      dbl   <= d;
      valid <= 1'b1;
      @(negedge clk);
      valid <= 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic select_dev();
      cs_n <= 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic deselect_dev();
      cs_n <= 1'b1;
      repeat (8) @(negedge clk);
   endtask

   task automatic clk_bits(input int first, input int n);
      for (int i = 0; i < n; i++) begin
         rx[23-first-i] = sdo;
         sck <= 1'b1;
         repeat (H) @(negedge clk);
         sck <= 1'b0;
         repeat (H) @(negedge clk);
      end
   endtask

   task automatic conv(input int v, input bit d);
      logic [17:0] ec;
      string       t;
      t = tag_of(v, d);
      send(v, d, ec);
      chk(ready === 1'b1, "R10 ready after result", {31'd0, ready}, 32'd1);
      chk(sdo === 1'b0, "R12 idle sdo", {31'd0, sdo}, 32'd0);
      select_dev();
      clk_bits(0, 24);
      chk(rx[17+4:4] === ec, {t, " code R9"}, {14'd0, rx[21:4]}, {14'd0, ec});
      chk(rx[23:22] === 2'b00 && rx[3:0] === 4'h0, "R2 header/tail", {8'd0, rx}, {14'd0, ec, 4'h0});
      chk(ready === 1'b0, "R10 clear after 24", {31'd0, ready}, 32'd0);
      deselect_dev();
      last_code = ec;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [17:0] ea, eb;
      repeat (4) @(negedge clk);
      rst_n <= 1'b1;
      repeat (6) @(negedge clk);
      // R1 reset state
      chk(ready === 1'b0, "R1 ready at reset", {31'd0, ready}, 32'd0);
      chk(sdo === 1'b1, "R1 sdo at reset", {31'd0, sdo}, 32'd1);

      // boundaries in 1x mode
      conv(FS - 1, 0);  conv(FS, 0);  conv(FS + 1, 0);  conv(524287, 0);
      conv(FS / 2, 0);  conv(FS / 2 - 1, 0);  conv(1, 0);  conv(0, 0);
      conv(-1, 0);  conv(-FS / 2, 0);  conv(-FS / 2 - 1, 0);
      conv(-FS, 0);  conv(-FS - 1, 0);  conv(-FS + 1, 0);  conv(-524288, 0);

      // sweep of the whole input range
      for (int k = -64; k < 64; k++) conv(k * 8191 + 3, 0);

      // R8 zero sign alternation in double-rate mode
      conv(0, 1);  conv(0, 1);  conv(5, 1);  conv(0, 1);
      conv(0, 0);  conv(0, 1);  conv(-7, 1); conv(0, 1);

      // R2 stale read: status 1, previous code repeated
      select_dev();
      clk_bits(0, 24);
      chk(rx[23] === 1'b1, "R2 stale status", {31'd0, rx[23]}, 32'd1);
      chk(rx[21:4] === last_code, "R2 stale code", {14'd0, rx[21:4]}, {14'd0, last_code});
      deselect_dev();
      chk(sdo === 1'b1, "R12 idle sdo no pending", {31'd0, sdo}, 32'd1);

      // R10 aborted transfer keeps ready
      send(12345, 0, ea);
      select_dev();
      clk_bits(0, 10);
      deselect_dev();
      chk(ready === 1'b1, "R10 abort keeps ready", {31'd0, ready}, 32'd1);
      select_dev();
      clk_bits(0, 24);
      chk(rx === {2'b00, ea, 4'h0}, "R10 full reread after abort", {8'd0, rx}, {8'd0, 2'b00, ea, 4'h0});
      deselect_dev();

      // R11 result arriving mid-transfer is deferred
      send(-20000, 0, ea);
      select_dev();
      clk_bits(0, 12);
      send(FS + 9, 0, eb);
      clk_bits(12, 12);
      chk(rx === {2'b00, ea, 4'h0}, "R11 word unchanged", {8'd0, rx}, {8'd0, 2'b00, ea, 4'h0});
      chk(ready === 1'b0, "R11 ready stays low while selected", {31'd0, ready}, 32'd0);
      deselect_dev();
      chk(ready === 1'b1, "R11 deferred result pending", {31'd0, ready}, 32'd1);
      select_dev();
      clk_bits(0, 24);
      chk(rx === {2'b00, eb, 4'h0}, "R11 deferred word", {8'd0, rx}, {8'd0, 2'b00, eb, 4'h0});
      deselect_dev();

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule